// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a memory access made by a hart is permitted. Software programs a set of protection entries through a CSR write port. Each entry holds a configuration byte and a 32-bit address register. The configuration byte carries per-entry read, write and execute permissions and an address-matching mode. Each access presents an address, an access kind and the current privilege level. One cycle later the block returns an allow or deny verdict, together with the index of the entry that decided it.

Entries are checked in index order, and the lowest-numbered entry that covers the address decides the access. Machine-mode accesses always pass. User and supervisor accesses that no entry covers are refused. Trap generation, the effect of the lock bit and CSR read-back belong to the surrounding core.

Top module: `pmp_checker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `resp_valid`, `resp_allow` and `resp_hit` are 0. All entries reset to mode off, so right after reset a user-mode access is refused with no hit.
- R2: An access with `acc_priv` = 3 (machine) is always allowed, whatever the entries hold. Privilege codes are 0 user, 1 supervisor and 3 machine. Any code other than 3 is checked against the entries.
- R3: A checked access (privilege other than 3) that no entry matches is denied, with `resp_hit` = 0.
- R4: Mode 1 (top-of-range) matches when prev ≤ A < cur. A is `acc_addr[33:2]`, cur is the entry's own address register and prev is the address register of the entry below it. Entry 0 uses 0 as prev. The entry below supplies prev even if its own mode is off.
- R5: Mode 2 (4-byte) matches when `acc_addr[33:2]` equals the address register.
- R6: Mode 3 (power-of-two) covers a naturally aligned region of 2^(t+3) bytes, where t is the number of trailing one bits in the address register. The upper bits of the register, above those t ones and the zero that follows them, give the base.
- R7: In configuration byte bit 0 permits read, bit 1 write and bit 2 execute. `acc_kind` is 0 for read, 1 for write and 2 for execute. Kind 3 is denied for a checked access, even when an entry matches.
- R8: When several entries match, the lowest-numbered one alone decides. A deny from it overrides an allow from a higher entry.
- R9: Mode 0 (off) never matches, whatever permission bits the entry carries.
- R10: A configuration write (`csr_is_addr` = 0) to CSR n places data byte k into entry 4n+k, with the mode in bits [4:3] of the byte. An address write (`csr_is_addr` = 1) loads entry `csr_idx`. A write takes effect for accesses presented in the following cycle.
- R11: `resp_valid` rises exactly one cycle after `acc_valid`. In a cycle after no access, `resp_valid`, `resp_allow`, `resp_hit` and `resp_index` are 0.
- R12: `resp_hit` and `resp_index` report the deciding entry in every privilege mode, machine mode included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write strobe |
| csr_is_addr | input | 1 | 1 writes an address register, 0 writes a configuration CSR |
| csr_idx | input | 4 | Entry index (address) or configuration CSR number |
| csr_wdata | input | 32 | CSR write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 34 | Physical byte address |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute |
| acc_priv | input | 2 | 0 user, 1 supervisor, 3 machine |
| resp_valid | output | 1 | Verdict valid, one cycle after the access |
| resp_allow | output | 1 | Access permitted |
| resp_hit | output | 1 | Some entry matched |
| resp_index | output | 4 | Index of the deciding entry |

## Verification
Every verdict is registered once, so all four response outputs for an access driven before edge n are read in the half cycle after edge n. The bench drives on the falling edge, waits one rising edge and samples at the next falling edge. A CSR write is applied at one rising edge and then trusted from the next access onward, so the bench never overlaps a write with a probe. Idle behaviour is read one cycle after the probe in which `acc_valid` was dropped.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

    localparam int unsigned ADDR_W = 34;
    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam int unsigned CSR_W  = 32;
    localparam int unsigned ENTRIES_PER_CSR = CSR_W / 8;

    typedef enum logic [1:0] {
        PRIV_USER    = 2'd0,
        PRIV_SUPER   = 2'd1,
        PRIV_RSVD    = 2'd2,
        PRIV_MACHINE = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    // Stored part of a configuration byte: bits [4:0].
    typedef struct packed {
        amode_e mode;
        logic   x;
        logic   w;
        logic   r;
    } ecfg_t;

    localparam int unsigned ECFG_W = $bits(ecfg_t);

    function automatic logic perm_ok(ecfg_t c, acc_e k);
        case (k)
            ACC_READ:  return c.r;
            ACC_WRITE: return c.w;
            ACC_EXEC:  return c.x;
            default:   return 1'b0;
        endcase
    endfunction

    // Ones in every bit compared for a power-of-two region.
    function automatic logic [WORD_W-1:0] napot_keep(logic [WORD_W-1:0] a);
        logic [WORD_W-1:0] inc;
        inc = a + WORD_W'(1);
        return ~(a ^ inc);
    endfunction

endpackage

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
    import pmp_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 16,
    localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we,
    input  logic                                is_addr,
    input  logic [IDX_W-1:0]                    idx,
    input  logic [CSR_W-1:0]                    wdata,
    output ecfg_t [NUM_ENTRIES-1:0]             cfg_q,
    output logic  [NUM_ENTRIES-1:0][WORD_W-1:0] addr_q
);

    // Bits [7:5] of each configuration byte are not kept.
    logic unused_high_bits;
    always_comb begin
        unused_high_bits = 1'b0;
        for (int b = 0; b < int'(ENTRIES_PER_CSR); b++) begin
            unused_high_bits = unused_high_bits ^ (^wdata[8*b+ECFG_W +: 8-ECFG_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            addr_q <= '0;
        end else if (we) begin
            for (int e = 0; e < int'(NUM_ENTRIES); e++) begin
                if (is_addr && idx == IDX_W'(e)) begin
                    addr_q[e] <= wdata[WORD_W-1:0];
                end
                if (!is_addr && idx == IDX_W'(e / int'(ENTRIES_PER_CSR))) begin
                    cfg_q[e] <= ecfg_t'(wdata[8*(e % int'(ENTRIES_PER_CSR)) +: ECFG_W]);
                end
            end
        end
    end

endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
    import pmp_pkg::*;
(
    input  amode_e            mode,
    input  logic [WORD_W-1:0] entry_addr,
    input  logic [WORD_W-1:0] word,
    input  logic              below_prev,
    output logic              below_self,
    output logic              hit
);

    logic [WORD_W-1:0] keep;

    always_comb begin
        below_self = word < entry_addr;
        keep       = napot_keep(entry_addr);
        case (mode)
            AM_TOR:   hit = !below_prev && below_self;
            AM_NA4:   hit = word == entry_addr;
            AM_NAPOT: hit = ((word ^ entry_addr) & keep) == '0;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmp_first_hit.sv
module pmp_first_hit #(
    parameter int unsigned NUM_ENTRIES = 16,
    localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] hits,
    output logic                   any,
    output logic [IDX_W-1:0]       idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = int'(NUM_ENTRIES) - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
    import pmp_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 16,
    localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_we,
    input  logic              csr_is_addr,
    input  logic [IDX_W-1:0]  csr_idx,
    input  logic [CSR_W-1:0]  csr_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        acc_priv,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic              resp_hit,
    output logic [IDX_W-1:0]  resp_index
);

    ecfg_t [NUM_ENTRIES-1:0]             cfg_q;
    logic  [NUM_ENTRIES-1:0][WORD_W-1:0] addr_q;
    logic  [NUM_ENTRIES-1:0]             below;
    logic  [NUM_ENTRIES-1:0]             hits;
    logic  [WORD_W-1:0]                  word;
    logic                                any_hit;
    logic  [IDX_W-1:0]                   first_idx;
    logic                                allow_d;
    logic                                unused_byte_offset;

    assign word               = acc_addr[ADDR_W-1:2];
    assign unused_byte_offset = ^acc_addr[1:0];

    pmp_csr_bank #(.NUM_ENTRIES(NUM_ENTRIES)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (csr_we),
        .is_addr (csr_is_addr),
        .idx     (csr_idx),
        .wdata   (csr_wdata),
        .cfg_q   (cfg_q),
        .addr_q  (addr_q)
    );

    for (genvar g = 0; g < int'(NUM_ENTRIES); g++) begin : g_entry
        logic below_prev;
        if (g == 0) begin : g_first
            assign below_prev = 1'b0;
        end else begin : g_rest
            assign below_prev = below[g-1];
        end
        pmp_region_match u_match (
            .mode       (cfg_q[g].mode),
            .entry_addr (addr_q[g]),
            .word       (word),
            .below_prev (below_prev),
            .below_self (below[g]),
            .hit        (hits[g])
        );
    end

    pmp_first_hit #(.NUM_ENTRIES(NUM_ENTRIES)) u_first (
        .hits (hits),
        .any  (any_hit),
        .idx  (first_idx)
    );

    always_comb begin
        if (priv_e'(acc_priv) == PRIV_MACHINE) begin
            allow_d = 1'b1;
        end else begin
            allow_d = any_hit && perm_ok(cfg_q[first_idx], acc_e'(acc_kind));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !acc_valid) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
            resp_hit   <= 1'b0;
            resp_index <= '0;
        end else begin
            resp_valid <= 1'b1;
            resp_allow <= allow_d;
            resp_hit   <= any_hit;
            resp_index <= first_idx;
        end
    end

endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva
    import pmp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       acc_valid,
    input logic [1:0] acc_kind,
    input logic [1:0] acc_priv,
    input logic       resp_valid,
    input logic       resp_allow,
    input logic       resp_hit
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!resp_valid && !resp_allow && !resp_hit));

    assert_machine_allows_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_priv == 2'd3) |=> resp_allow);

    assert_nohit_denies_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_priv != 2'd3) |=> (resp_hit || !resp_allow));

    assert_rsvd_kind_denied_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_priv != 2'd3 && acc_kind == 2'd3) |=> !resp_allow);

    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> resp_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!resp_valid && !resp_allow && !resp_hit));

endmodule

bind pmp_checker pmp_checker_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_kind   (acc_kind),
    .acc_priv   (acc_priv),
    .resp_valid (resp_valid),
    .resp_allow (resp_allow),
    .resp_hit   (resp_hit)
);

// File: tb/pmp_checker_bench.sv
module pmp_checker_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic        csr_is_addr = 1'b0;
    logic [3:0]  csr_idx = '0;
    logic [31:0] csr_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [33:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic [1:0]  acc_priv = '0;
    logic        resp_valid;
    logic        resp_allow;
    logic        resp_hit;
    logic [3:0]  resp_index;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [1:0] U = 2'd0, S = 2'd1, M = 2'd3;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2, RSV = 2'd3;

    always #5 clk = ~clk;

    pmp_checker u_pmp_checker (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_is_addr(csr_is_addr),
        .csr_idx(csr_idx), .csr_wdata(csr_wdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_priv(acc_priv),
        .resp_valid(resp_valid), .resp_allow(resp_allow), .resp_hit(resp_hit),
        .resp_index(resp_index)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit is_addr, input int idx, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_is_addr = is_addr; csr_idx = 4'(idx); csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic probe(input logic [33:0] a, input logic [1:0] k, input logic [1:0] p,
                         input bit e_allow, input bit e_hit, input int e_idx, input string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_priv = p;
        @(negedge clk);
        chk({req, " valid"}, 32'(resp_valid), 32'd1);
        chk({req, " allow"}, 32'(resp_allow), 32'(e_allow));
        chk({req, " hit"}, 32'(resp_hit), 32'(e_hit));
        if (e_hit) chk({req, " index"}, 32'(resp_index), 32'(e_idx));
        acc_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 valid in reset", 32'(resp_valid), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", 32'(resp_valid), 32'd0);
        chk("R1 allow after reset", 32'(resp_allow), 32'd0);
        probe(34'h100, RD, U, 1'b0, 1'b0, 0, "R1 R3 user after reset");
        probe(34'h100, RD, M, 1'b1, 1'b0, 0, "R2 machine after reset");
    endtask

    task automatic t_tor;
        wr(1'b1, 0, 32'h40);
        wr(1'b0, 0, 32'h0000_0009);
        probe(34'h0,   RD, U, 1'b1, 1'b1, 0, "R4 tor low bound zero");
        probe(34'hFC,  RD, U, 1'b1, 1'b1, 0, "R4 tor top word");
        probe(34'h100, RD, U, 1'b0, 1'b0, 0, "R4 R3 tor upper excluded");
        probe(34'h10,  WR, U, 1'b0, 1'b1, 0, "R7 write without W");
    endtask

    task automatic t_na4;
        wr(1'b1, 1, 32'h100);
        wr(1'b0, 0, 32'h0000_1209);
        probe(34'h400, WR, S, 1'b1, 1'b1, 1, "R5 na4 exact");
        probe(34'h403, WR, S, 1'b1, 1'b1, 1, "R5 na4 last byte");
        probe(34'h404, WR, S, 1'b0, 1'b0, 0, "R5 na4 next word");
        probe(34'h3FC, WR, S, 1'b0, 1'b0, 0, "R5 na4 prev word");
    endtask

    task automatic t_napot;
        wr(1'b1, 2, 32'h5FF);
        wr(1'b0, 0, 32'h001C_1209);
        probe(34'h1000, EX, U, 1'b1, 1'b1, 2, "R6 napot base");
        probe(34'h1FFC, EX, U, 1'b1, 1'b1, 2, "R6 napot top");
        probe(34'h2000, EX, U, 1'b0, 1'b0, 0, "R6 napot above");
        probe(34'hFFC,  EX, U, 1'b0, 1'b0, 0, "R6 napot below");
        probe(34'h1800, RD, U, 1'b0, 1'b1, 2, "R7 read without R");
    endtask

    task automatic t_priority;
        wr(1'b1, 3, 32'h1FFF);
        wr(1'b0, 0, 32'h1F1C_1209);
        probe(34'h1800, RD, U, 1'b0, 1'b1, 2, "R8 lower entry denies");
        probe(34'h3000, RD, U, 1'b1, 1'b1, 3, "R8 R6 wide region");
        probe(34'h50,   WR, U, 1'b0, 1'b1, 0, "R8 entry0 beats entry3");
        probe(34'h50,   RD, S, 1'b1, 1'b1, 0, "R8 entry0 read");
    endtask

    task automatic t_off_bound;
        wr(1'b1, 4, 32'h8000);
        wr(1'b1, 5, 32'h8100);
        wr(1'b0, 1, 32'h0000_0907);
        probe(34'h20000, RD, U, 1'b1, 1'b1, 5, "R4 R9 tor bound from off entry");
        probe(34'h1FFFC, RD, U, 1'b0, 1'b0, 0, "R9 off entry no match");
        probe(34'h203FC, WR, U, 1'b0, 1'b1, 5, "R7 tor no W");
    endtask

    task automatic t_packing;
        wr(1'b1, 15, 32'h30000);
        wr(1'b0, 3, 32'h1100_0000);
        probe(34'hC0000, RD, U, 1'b1, 1'b1, 15, "R10 csr3 byte3 entry15");
        probe(34'hC0004, RD, U, 1'b0, 1'b0, 0, "R10 R5 entry15 na4 only");
    endtask

    task automatic t_rsvd_kind;
        probe(34'h50, RSV, U, 1'b0, 1'b1, 0, "R7 reserved kind");
    endtask

    task automatic t_machine;
        probe(34'h1FFFC, WR, M, 1'b1, 1'b0, 0, "R2 machine no match");
        probe(34'h1800,  RD, M, 1'b1, 1'b1, 2, "R2 R12 machine index");
    endtask

    task automatic t_idle;
        probe(34'h50, RD, U, 1'b1, 1'b1, 0, "R11 before idle");
        @(negedge clk);
        chk("R11 idle valid", 32'(resp_valid), 32'd0);
        chk("R11 idle allow", 32'(resp_allow), 32'd0);
        chk("R11 idle hit", 32'(resp_hit), 32'd0);
        chk("R11 idle index", 32'(resp_index), 32'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_tor;
        t_na4;
        t_napot;
        t_priority;
        t_off_bound;
        t_packing;
        t_rsvd_kind;
        t_machine;
        t_idle;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end

endmodule